// File: doc/BRIEF.md
# Voice Channel Command and Status Registers

This block holds the per-channel run state and the small per-channel flags of a multichannel sampled-audio voice engine. Software reaches it through a plain register bus: one cycle carries an address, a write enable and write data, and read data is returned in the same cycle from the addressed register. Each 32-bit register maps bit n to channel n. The block does not contain the address or envelope engines. It sends them one-cycle command pulses and takes back their event strobes.

Each register follows its own write rule. Two command words start or stop channels when a bit is written as one. Because the stop word clears bits, it works as a write-one-to-clear location. The delay and loop-sign flags can only be set by software, and the engines otherwise drive them. The envelope buffer select toggles on a one. Stopping a channel also clears every flag of that channel. The current buffer select goes out on a port so the envelope engine can read it continuously.

Top module: `voice_ctl_regs`

## Requirements
- R1: After reset every register reads 0 and no start, stop or buffer-flip pulse is asserted.
- R2: A write to offset 80h sets run status bit n for each one in the data, leaves bits written as zero unchanged, and in the next cycle raises `start_pulse` equal to the written data for exactly one cycle.
- R3: A write to offset 84h clears run status bit n for each one in the data and in the next cycle raises `stop_pulse` equal to the written data for exactly one cycle.
- R4: Reads of 80h and 84h both return the run status. Reads of 88h, 8Ch and 94h return the delay, loop-sign and buffer-select flags. Any other offset reads 0.
- R5: A stop of channel n forces its delay, loop-sign and buffer-select bits to 0. This takes priority over any engine event or other update to that channel in the same cycle.
- R6: The delay flag (88h) is set by a software write of 1 or by `eng_dly_set`, and cleared by `eng_dly_clr`. A written 0 is ignored. A set, from software or the engine, wins over a same-cycle clear.
- R7: The loop-sign bit (8Ch) is set by a software write of 1, and a written 0 is ignored. When `eng_sgn_upd` bit n is high, the bit loads `eng_sgn_val` bit n (1 = sample address below loop begin). A software set wins over a same-cycle engine update.
- R8: Writing 1 to bit n of 94h toggles buffer select n (0 = first buffer, 1 = second buffer) and pulses `flip_pulse` bit n for one cycle in the next cycle. A written 0 changes nothing. `buf_sel` always shows the current selection.
- R9: Writes to unmapped offsets change no register and raise no pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| bus_addr | input | 8 | Register byte offset |
| bus_we | input | 1 | Write enable |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data of addressed register, same cycle |
| eng_dly_set | input | 32 | Envelope engine entered a delay-mode buffer |
| eng_dly_clr | input | 32 | Envelope engine entered a non-delay buffer |
| eng_sgn_upd | input | 32 | Address engine loop-sign update strobe |
| eng_sgn_val | input | 32 | Loop-sign value for the update |
| start_pulse | output | 32 | One-cycle start command per channel |
| stop_pulse | output | 32 | One-cycle stop command per channel |
| flip_pulse | output | 32 | One-cycle buffer-switch command per channel |
| buf_sel | output | 32 | Current envelope buffer select per channel |

## Verification
The hardest cases to reach are same-cycle collisions. These are a stop write that lands together with engine strobes trying to set the delay and sign flags of the same channels, and a software set that meets an engine clear or engine update on the same bit. The stimulus drives each engine strobe in the same cycle as the colliding bus write. It first loads the flags to known values so that every winner leaves a visible result. A readback of every register after each collision then shows which source prevailed.

// File: rtl/voice_ctl_regs.sv
`timescale 1ns/1ps
module voice_ctl_regs #(
  parameter int NCH = 32,
  parameter int DW  = 32,
  parameter int AW  = 8,
  parameter logic [AW-1:0] OFS_START = 8'h80,
  parameter logic [AW-1:0] OFS_STOP  = 8'h84,
  parameter logic [AW-1:0] OFS_DLY   = 8'h88,
  parameter logic [AW-1:0] OFS_SGN   = 8'h8C,
  parameter logic [AW-1:0] OFS_BUF   = 8'h94
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic [AW-1:0]  bus_addr,
  input  logic           bus_we,
  input  logic [DW-1:0]  bus_wdata,
  output logic [DW-1:0]  bus_rdata,
  input  logic [NCH-1:0] eng_dly_set,
  input  logic [NCH-1:0] eng_dly_clr,
  input  logic [NCH-1:0] eng_sgn_upd,
  input  logic [NCH-1:0] eng_sgn_val,
  output logic [NCH-1:0] start_pulse,
  output logic [NCH-1:0] stop_pulse,
  output logic [NCH-1:0] flip_pulse,
  output logic [NCH-1:0] buf_sel
);
  logic [NCH-1:0] run_q, dly_q, sgn_q, buf_q;
  logic [NCH-1:0] wbits;
  logic [NCH-1:0] wr_start, wr_stop, wr_dly, wr_sgn, wr_buf;

  assign wbits    = bus_wdata[NCH-1:0];
  assign wr_start = (bus_we && bus_addr == OFS_START) ? wbits : '0;
  assign wr_stop  = (bus_we && bus_addr == OFS_STOP)  ? wbits : '0;
  assign wr_dly   = (bus_we && bus_addr == OFS_DLY)   ? wbits : '0;
  assign wr_sgn   = (bus_we && bus_addr == OFS_SGN)   ? wbits : '0;
  assign wr_buf   = (bus_we && bus_addr == OFS_BUF)   ? wbits : '0;

  always_comb begin
    case (bus_addr)
      OFS_START, OFS_STOP: bus_rdata = DW'(run_q);
      OFS_DLY:             bus_rdata = DW'(dly_q);
      OFS_SGN:             bus_rdata = DW'(sgn_q);
      OFS_BUF:             bus_rdata = DW'(buf_q);
      default:             bus_rdata = '0;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      run_q       <= '0;
      dly_q       <= '0;
      sgn_q       <= '0;
      buf_q       <= '0;
      start_pulse <= '0;
      stop_pulse  <= '0;
      flip_pulse  <= '0;
    end else begin
      run_q       <= (run_q | wr_start) & ~wr_stop;
      dly_q       <= ~wr_stop & ((dly_q & ~eng_dly_clr) | eng_dly_set | wr_dly);
      sgn_q       <= ~wr_stop & (wr_sgn | (eng_sgn_upd & eng_sgn_val) | (~eng_sgn_upd & sgn_q));
      buf_q       <= ~wr_stop & (buf_q ^ wr_buf);
      start_pulse <= wr_start;
      stop_pulse  <= wr_stop;
      flip_pulse  <= wr_buf;
    end
  end

  assign buf_sel = buf_q;
endmodule

// File: rtl/voice_ctl_regs_chk.sv
`timescale 1ns/1ps
module voice_ctl_regs_chk #(
  parameter int NCH = 32,
  parameter int DW  = 32,
  parameter int AW  = 8,
  parameter logic [AW-1:0] OFS_START = 8'h80,
  parameter logic [AW-1:0] OFS_STOP  = 8'h84,
  parameter logic [AW-1:0] OFS_BUF   = 8'h94
) (
  input logic           clk,
  input logic           rst_n,
  input logic [AW-1:0]  bus_addr,
  input logic           bus_we,
  input logic [DW-1:0]  bus_wdata,
  input logic [NCH-1:0] run_q,
  input logic [NCH-1:0] dly_q,
  input logic [NCH-1:0] sgn_q,
  input logic [NCH-1:0] buf_q,
  input logic [NCH-1:0] start_pulse,
  input logic [NCH-1:0] stop_pulse,
  input logic [NCH-1:0] flip_pulse
);
  assert_start_src_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (|start_pulse) |-> $past(bus_we && bus_addr == OFS_START));

  assert_run_set_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_we && bus_addr == OFS_START) |=>
      ((run_q & $past(bus_wdata[NCH-1:0])) == $past(bus_wdata[NCH-1:0])));

  assert_stop_src_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (|stop_pulse) |-> $past(bus_we && bus_addr == OFS_STOP));

  assert_stop_clears_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_we && bus_addr == OFS_STOP) |=>
      (((run_q | dly_q | sgn_q | buf_q) & $past(bus_wdata[NCH-1:0])) == '0));

  assert_buf_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !(bus_we && (bus_addr == OFS_STOP || bus_addr == OFS_BUF)) |=> $stable(buf_q));

  assert_flip_src_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (|flip_pulse) |-> $past(bus_we && bus_addr == OFS_BUF));
endmodule

bind voice_ctl_regs voice_ctl_regs_chk #(
  .NCH(NCH), .DW(DW), .AW(AW),
  .OFS_START(OFS_START), .OFS_STOP(OFS_STOP), .OFS_BUF(OFS_BUF)
) chk_i (
  .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_we(bus_we),
  .bus_wdata(bus_wdata), .run_q(run_q), .dly_q(dly_q), .sgn_q(sgn_q),
  .buf_q(buf_q), .start_pulse(start_pulse), .stop_pulse(stop_pulse),
  .flip_pulse(flip_pulse)
);

// File: tb/voice_ctl_regs_tb_top.sv
`timescale 1ns/1ps
module voice_ctl_regs_tb_top;
  logic        clk = 0;
  logic        rst_n = 0;
  logic [7:0]  bus_addr = '0;
  logic        bus_we = 0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic [31:0] eng_dly_set = '0, eng_dly_clr = '0, eng_sgn_upd = '0, eng_sgn_val = '0;
  logic [31:0] start_pulse, stop_pulse, flip_pulse, buf_sel;

  voice_ctl_regs dut_i (
    .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_we(bus_we),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .eng_dly_set(eng_dly_set), .eng_dly_clr(eng_dly_clr),
    .eng_sgn_upd(eng_sgn_upd), .eng_sgn_val(eng_sgn_val),
    .start_pulse(start_pulse), .stop_pulse(stop_pulse),
    .flip_pulse(flip_pulse), .buf_sel(buf_sel)
  );

  always #2.5 clk = ~clk;

  int cyc = 0;
  always @(posedge clk) cyc <= cyc + 1;

  typedef struct { int due; int sel; logic [31:0] exp; } item_t;
  item_t sb_q[$];
  string tag_q[$];
  int vectors = 0, miscompares = 0;
  bit done = 0;

  logic [31:0] m_run = '0, m_dly = '0, m_sgn = '0, m_buf = '0;

  function automatic logic [31:0] m_read(input logic [7:0] a);
    case (a)
      8'h80, 8'h84: return m_run;
      8'h88:        return m_dly;
      8'h8C:        return m_sgn;
      8'h94:        return m_buf;
      default:      return '0;
    endcase
  endfunction

  function automatic void push(input int due, input int sel, input logic [31:0] e, input string t);
    item_t it;
    it.due = due; it.sel = sel; it.exp = e;
    sb_q.push_back(it);
    tag_q.push_back(t);
  endfunction

  task automatic op(input logic we, input logic [7:0] a, input logic [31:0] d,
                    input string req,
                    input logic [31:0] ds = '0, input logic [31:0] dc = '0,
                    input logic [31:0] su = '0, input logic [31:0] sv = '0);
    logic [31:0] st, sp, dw, sw, tg;
    @(posedge clk); #1;
    bus_we = we; bus_addr = a; bus_wdata = d;
    eng_dly_set = ds; eng_dly_clr = dc; eng_sgn_upd = su; eng_sgn_val = sv;
    if (!we) push(cyc, 0, m_read(a), req);
    st = (we && a == 8'h80) ? d : '0;
    sp = (we && a == 8'h84) ? d : '0;
    dw = (we && a == 8'h88) ? d : '0;
    sw = (we && a == 8'h8C) ? d : '0;
    tg = (we && a == 8'h94) ? d : '0;
    m_run = (m_run | st) & ~sp;
    m_dly = ~sp & ((m_dly & ~dc) | ds | dw);
    m_sgn = ~sp & (sw | (su & sv) | (~su & m_sgn));
    m_buf = ~sp & (m_buf ^ tg);
    push(cyc + 1, 1, st, req);
    push(cyc + 1, 2, sp, req);
    push(cyc + 1, 3, tg, req);
    push(cyc + 1, 4, m_buf, req);
  endtask

  task automatic rd(input logic [7:0] a, input string req);
    op(0, a, '0, req);
  endtask

  task automatic rd_all(input string req);
    rd(8'h80, req); rd(8'h84, req); rd(8'h88, req);
    rd(8'h8C, req); rd(8'h94, req); rd(8'h90, req);
  endtask

  always @(negedge clk) begin
    item_t it;
    string t;
    logic [31:0] act;
    while (sb_q.size() > 0 && sb_q[0].due <= cyc) begin
      it = sb_q.pop_front();
      t  = tag_q.pop_front();
      case (it.sel)
        0: act = bus_rdata;
        1: act = start_pulse;
        2: act = stop_pulse;
        3: act = flip_pulse;
        default: act = buf_sel;
      endcase
      vectors++;
      if (act !== it.exp) begin
        miscompares++;
        $display("FAIL %s port%0d actual=%h expected=%h at cycle %0d", t, it.sel, act, it.exp, cyc);
      end
    end
  end

  initial begin
    #1ms;
    if (!done) begin
      miscompares++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    #1 rst_n = 1;
    rd_all("R1");                                  // R1 reset state
    op(1, 8'h80, 32'hA5A5_0F0F, "R2");             // R2 start
    rd(8'h80, "R2"); rd(8'h84, "R4");              // R4 same status
    op(1, 8'h80, 32'h0000_1000, "R2");             // zeros leave others
    op(1, 8'h80, 32'h0000_0001, "R2");             // back-to-back pulses
    rd(8'h80, "R2");
    op(1, 8'h84, 32'h0000_0F00, "R3");             // R3 stop
    rd(8'h84, "R3");
    op(1, 8'h88, 32'h0000_00F0, "R6");             // R6 software set
    op(1, 8'h88, 32'h0000_0000, "R6");             // written 0 ignored
    rd(8'h88, "R6");
    op(0, 8'h00, '0, "R6", 32'h3);                 // engine set
    op(0, 8'h00, '0, "R6", '0, 32'h10);            // engine clear
    op(1, 8'h88, 32'h20, "R6", '0, 32'h20);        // sw set beats engine clear
    rd(8'h88, "R6");
    op(1, 8'h8C, 32'h0000_000F, "R7");             // R7 software set
    op(1, 8'h8C, 32'h0, "R7");
    op(0, 8'h00, '0, "R7", '0, '0, 32'h30, 32'h10);
    op(0, 8'h00, '0, "R7", '0, '0, 32'h2, 32'h0);  // engine clears bit1
    op(1, 8'h8C, 32'h1, "R7", '0, '0, 32'h1, 32'h0);
    rd(8'h8C, "R7");
    op(1, 8'h94, 32'h3, "R8");                     // R8 toggle
    op(1, 8'h94, 32'h1, "R8");
    op(1, 8'h94, 32'h0, "R8");
    rd(8'h94, "R8");
    op(1, 8'h94, 32'h8000_0010, "R8");
    rd_all("R8");
    op(1, 8'h84, 32'h0000_00FF, "R5", 32'h1, '0, 32'h1, 32'h1); // R5 stop vs engine
    rd_all("R5");
    op(1, 8'h90, 32'hFFFF_FFFF, "R9");             // R9 unmapped write
    op(1, 8'h00, 32'hFFFF_FFFF, "R9");
    rd_all("R9");
    rd(8'h90, "R4");
    rd(8'h04, "R4");
    rd(8'h80, "R4");
    repeat (3) @(posedge clk);
    @(negedge clk); #1;
    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end
endmodule